// File: doc/BRIEF.md
# Serial 4x4 Forward Integer Transform Engine

This block turns a 4x4 block of signed residual samples into the 4x4 coefficients of the integer core transform used in block-based video coding. The 2-D transform is split into two 1-D four-point passes. A single combinational butterfly unit serves both passes. Each incoming column goes through the butterfly as it is accepted, and the result is stored as one column of a register transpose buffer. When the fourth column has been stored, the same butterfly reads the buffer one row at a time and produces the output rows. The datapath has no multipliers. It uses only adds, subtracts and one-bit shifts.

The upstream side delivers one column per cycle over a valid/ready handshake. The downstream side takes one coefficient row per handshake and may apply backpressure. The buffer has a single bank, so the block takes no new column while a block is being drained. A full block therefore occupies the engine for at least eight cycles.

Top module: `xfm4_serial_core`

## Requirements
- R1: After reset, in_ready_o is 1 and out_valid_o is 0.
- R2: A column is accepted on a rising edge where in_valid_i and in_ready_o are both 1. The columns of a block are taken in order, column 0 to column 3. Within in_col_i, bits [9k+8:9k] carry the two's-complement sample of row k.
- R3: For a block X, the outputs equal Y = C·X·Cᵀ, where the rows of C are (1,1,1,1), (2,1,-1,-2), (1,-1,-1,1) and (1,-2,2,-1). Within out_row_o, bits [16k+15:16k] carry the 16-bit two's-complement coefficient of column k for the current row.
- R4: The rows go out in the order row 0 to row 3. out_last_o is 1 exactly while row 3 is presented.
- R5: out_valid_o is 1 in the cycle right after the fourth column is accepted, and row 0 is presented in that cycle.
- R6: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_row_o and out_last_o do not change.
- R7: From the fourth column accept until the row-3 handshake, in_ready_o is 0. Any in_valid_i or in_col_i activity in that window has no effect on the rows produced.
- R8: In the cycle after the row-3 handshake, in_ready_o is 1 and out_valid_o is 0.
- R9: Full-scale inputs (all samples -256, all 255, or alternating extremes) give exact results with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Column offered |
| in_ready_o | output | 1 | Engine can take a column |
| in_col_i | input | 4*IN_W (36) | One residual column, row k in slice k |
| out_valid_o | output | 1 | Coefficient row presented |
| out_ready_i | input | 1 | Downstream takes the row |
| out_row_o | output | 4*COEF_W (64) | One coefficient row, column k in slice k |
| out_last_o | output | 1 | Presented row is row 3 |

## Verification
The fourth column accept is followed one cycle later by row 0 on the output. Each following row is due one cycle after the handshake on the previous row. in_ready_o returns one cycle after the row-3 handshake. The bench drives inputs and samples outputs on falling edges, so every check lands in the cycle after the edge that should have caused the change. The bench also holds out_ready_i low for a varying number of cycles on each row, and it drives junk columns during the drain phase. This confirms that the held row, the last flag and the next block all stay correct. Expected coefficients come from a direct matrix product in the bench, over impulses at all sixteen positions, full-scale blocks and pseudo-random blocks.

// File: rtl/xfm4_pkg.sv
package xfm4_pkg;
  localparam int unsigned NPT = 4;
  localparam int unsigned IDX_W = $clog2(NPT);
  typedef enum logic {PH_FILL = 1'b0, PH_DRAIN = 1'b1} phase_e;
endpackage

// File: rtl/xfm4_bfly.sv
module xfm4_bfly
  import xfm4_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic signed [W-1:0] x_i [NPT],
  output logic signed [W-1:0] y_o [NPT]
);
  logic signed [W-1:0] s0, s1, d0, d1;
  logic signed [W-1:0] chk_lhs, chk_rhs;

  always_comb begin
    s0 = x_i[0] + x_i[3];
    s1 = x_i[1] + x_i[2];
    d0 = x_i[0] - x_i[3];
    d1 = x_i[1] - x_i[2];
    y_o[0] = s0 + s1;
    y_o[2] = s0 - s1;
    y_o[1] = (d0 <<< 1) + d1;
    y_o[3] = d0 - (d1 <<< 1);
  end

  always_comb begin
    chk_lhs = y_o[0] + y_o[2];
    chk_rhs = (x_i[0] + x_i[3]) <<< 1;
    // R3
    pair_sum_chk: assert (chk_lhs == chk_rhs);
  end
endmodule

// File: rtl/xfm4_tbuf.sv
module xfm4_tbuf
  import xfm4_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_col_i,
  input  logic signed [W-1:0] wr_data_i [NPT],
  input  logic [IDX_W-1:0]    rd_row_i,
  output logic signed [W-1:0] rd_data_o [NPT]
);
  logic signed [W-1:0] cell_q [NPT][NPT];

  for (genvar r = 0; r < NPT; r++) begin : g_row
    for (genvar c = 0; c < NPT; c++) begin : g_col
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cell_q[r][c] <= '0;
        else if (wr_en_i && wr_col_i == IDX_W'(c)) cell_q[r][c] <= wr_data_i[r];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NPT; c++) rd_data_o[c] = cell_q[rd_row_i][c];
  end
endmodule

// File: rtl/xfm4_seq.sv
module xfm4_seq
  import xfm4_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             out_ready_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic             out_last_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] idx_o,
  output phase_e           phase_o
);
  phase_e           phase_q;
  logic [IDX_W-1:0] cnt_q;
  logic             in_fire, out_fire, cnt_end;

  assign in_ready_o  = (phase_q == PH_FILL);
  assign out_valid_o = (phase_q == PH_DRAIN);
  assign cnt_end     = (cnt_q == IDX_W'(NPT - 1));
  assign out_last_o  = out_valid_o && cnt_end;
  assign in_fire     = in_valid_i && in_ready_o;
  assign out_fire    = out_valid_o && out_ready_i;
  assign wr_en_o     = in_fire;
  assign idx_o       = cnt_q;
  assign phase_o     = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FILL;
      cnt_q   <= '0;
    end else if (in_fire || out_fire) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_end) phase_q <= in_fire ? PH_DRAIN : PH_FILL;
    end
  end

  // R5
  fill_to_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fire && cnt_end) |=> (out_valid_o && !out_last_o));
  // R7
  drain_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !(out_ready_i && out_last_o)) |=> !in_ready_o);
  // R8
  drain_to_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_fire && out_last_o) |=> (in_ready_o && !out_valid_o));
endmodule

// File: rtl/xfm4_serial_core.sv
module xfm4_serial_core
  import xfm4_pkg::*;
#(
  parameter int unsigned IN_W   = 9,
  parameter int unsigned COEF_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [NPT*IN_W-1:0]     in_col_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [NPT*COEF_W-1:0]   out_row_o,
  output logic                    out_last_o
);
  logic signed [COEF_W-1:0] ext_col [NPT];
  logic signed [COEF_W-1:0] buf_row [NPT];
  logic signed [COEF_W-1:0] bf_in   [NPT];
  logic signed [COEF_W-1:0] bf_out  [NPT];
  logic                     wr_en;
  logic [IDX_W-1:0]         idx;
  phase_e                   phase;

  for (genvar k = 0; k < NPT; k++) begin : g_lane
    assign ext_col[k] = COEF_W'($signed(in_col_i[k*IN_W +: IN_W]));
    assign bf_in[k]   = (phase == PH_FILL) ? ext_col[k] : buf_row[k];
    assign out_row_o[k*COEF_W +: COEF_W] = bf_out[k];
  end

  xfm4_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .wr_en_o     (wr_en),
    .idx_o       (idx),
    .phase_o     (phase)
  );

  xfm4_bfly #(.W(COEF_W)) u_bfly (
    .x_i (bf_in),
    .y_o (bf_out)
  );

  xfm4_tbuf #(.W(COEF_W)) u_tbuf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_col_i  (idx),
    .wr_data_i (bf_out),
    .rd_row_i  (idx),
    .rd_data_o (buf_row)
  );

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_row_o) && $stable(out_last_o)));
endmodule

// File: tb/xfm4_serial_core_tb.sv
`timescale 1ns/1ps
module xfm4_serial_core_tb;
  localparam int IN_W = 9;
  localparam int CW   = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic out_ready_i = 1'b0;
  logic [4*IN_W-1:0] in_col_i = '0;
  logic in_ready_o, out_valid_o, out_last_o;
  logic [4*CW-1:0] out_row_o;

  int nchk = 0;
  int nerr = 0;
  int xm [4][4];
  int ym [4][4];
  int cm [4][4] = '{'{1, 1, 1, 1}, '{2, 1, -1, -2}, '{1, -1, -1, 1}, '{1, -2, 2, -1}};
  int unsigned lcg = 32'h1234_5678;

  always #2 clk_i = ~clk_i;

  xfm4_serial_core u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_col_i    (in_col_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_row_o   (out_row_o),
    .out_last_o  (out_last_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int coef(input int k);
    return int'($signed(out_row_o[k*CW +: CW]));
  endfunction

  function automatic void compute_expected();
    int z [4][4];
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        z[i][j] = 0;
        for (int m = 0; m < 4; m++) z[i][j] += cm[i][m] * xm[m][j];
      end
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        ym[i][j] = 0;
        for (int m = 0; m < 4; m++) ym[i][j] += z[i][m] * cm[j][m];
      end
  endfunction

  task automatic run_block(input int blk, input string rq);
    logic [4*CW-1:0] held;
    bit held_last;
    compute_expected();
    // R2: columns 0..3, row k in slice k
    for (int c = 0; c < 4; c++) begin
      @(negedge clk_i);
      in_valid_i = 1'b1;
      for (int k = 0; k < 4; k++) in_col_i[k*IN_W +: IN_W] = IN_W'(xm[k][c]);
      while (!in_ready_o) @(negedge clk_i);
      @(posedge clk_i);
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    // R5
    chk(out_valid_o == 1'b1, "R5", out_valid_o, 1);
    // R7
    chk(in_ready_o == 1'b0, "R7", in_ready_o, 0);
    if (blk % 2 == 1) begin
      in_valid_i = 1'b1;
      in_col_i   = '1;
    end
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 4; k++)
        chk(coef(k) == ym[r][k], rq, coef(k), ym[r][k]);
      // R4
      chk(out_last_o == (r == 3), "R4", out_last_o, (r == 3));
      chk(out_valid_o == 1'b1, "R4", out_valid_o, 1);
      // R7
      chk(in_ready_o == 1'b0, "R7", in_ready_o, 0);
      held = out_row_o;
      held_last = out_last_o;
      for (int s = 0; s < (blk + r) % 3; s++) begin
        out_ready_i = 1'b0;
        @(posedge clk_i);
        @(negedge clk_i);
        // R6
        chk(out_valid_o && out_row_o == held && out_last_o == held_last, "R6",
            int'(out_row_o[CW-1:0]), int'(held[CW-1:0]));
      end
      out_ready_i = 1'b1;
      @(posedge clk_i);
      @(negedge clk_i);
      out_ready_i = 1'b0;
    end
    in_valid_i = 1'b0;
    // R8
    chk(in_ready_o == 1'b1, "R8", in_ready_o, 1);
    chk(out_valid_o == 1'b0, "R8", out_valid_o, 0);
  endtask

  function automatic int next_rand();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 16) % 512) - 256;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    nerr++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(in_ready_o == 1'b1, "R1", in_ready_o, 1);
    chk(out_valid_o == 1'b0, "R1", out_valid_o, 0);

    for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) xm[i][j] = 0;
    run_block(0, "R3");
    // R9: full-scale blocks
    for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) xm[i][j] = 255;
    run_block(1, "R9");
    for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) xm[i][j] = -256;
    run_block(2, "R9");
    for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) xm[i][j] = ((i + j) % 2) ? -256 : 255;
    run_block(3, "R9");
    for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) xm[i][j] = (cm[i][j] * cm[j][i] > 0) ? 255 : -256;
    run_block(4, "R9");
    // R3: impulse at every position
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) xm[i][j] = (i * 4 + j == p) ? ((p % 2) ? -1 : 1) : 0;
      run_block(5 + p, "R3");
    end
    // R3: pseudo-random blocks
    for (int b = 0; b < 24; b++) begin
      for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) xm[i][j] = next_rand();
      run_block(21 + b, "R3");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule